// File: doc/BRIEF.md
# SAR Converter Serial Frame Port

This block is the device side of the serial link on a four-channel, 16-bit sampling converter. The host drives an active-low chip select, a serial clock and a serial data line. The block brings all three into the system clock through synchronizer flops and detects their edges there. It returns conversion results on a serial output that has its own enable, so the pad can float the line whenever the enable is low.

A frame opens when chip select falls. In that cycle the block sends a one-cycle sample request, carrying the channel that was chosen during the previous frame, to a result port. That port stands in for the converter core and later hands back a 16-bit result with a valid strobe. Over the first 16 serial-clock falling edges the block shifts in a command word, most significant bit first. A complete command can choose the channel for the next frame or switch the output frame between a long form (32 edges, 16 result bits) and a short form (24 edges, the upper 8 result bits). A changed setting takes effect at the next chip-select falling edge. The serial output stays low through the command phase, then presents the result one bit per falling edge, then stays low until chip select rises.

Top module: `sar_serial_port`

## Requirements
- R1: While the synchronized chip select is high, `sdo_oe_o` is 0 and `sdo_o` is 0 (line floated). While it is low, `sdo_oe_o` is 1, and before the first serial-clock falling edge of the frame `sdo_o` is 0.
- R2: Each chip-select falling edge produces exactly one `samp_req_o` pulse, one system clock wide. No pulse occurs at any other time.
- R3: `samp_ch_o` at the request is the channel set by the last completed select command of an earlier frame, not by the command of the current frame. After reset it is 0, and it holds its value through the frame.
- R4: The command word is captured from `sdi_i` on the first 16 serial-clock falling edges of a frame, MSB first. Opcode 4'h1 in bits 15:12 selects the channel in bits 1:0.
- R5: `sdo_o` is 0 after each of the first 15 serial-clock falling edges of a frame.
- R6: After falling edge 16 `sdo_o` carries bit 15 of the result latched from `samp_data_i` when `samp_vld_i` is high. Each later falling edge presents the next lower bit.
- R7: In the long form, which is the reset setting, result bits appear after falling edges 16 through 31. After edge 32 and any further edges, `sdo_o` is 0 until chip select rises.
- R8: Opcode 4'h2 with bit 0 = 1 selects the short form, and bit 0 = 0 selects the long form. The short form presents result bits 15..8 after edges 16 through 23 and 0 afterwards. The setting applies from the next frame on.
- R9: If chip select rises before 16 falling edges have been received, the partial command is discarded. Channel and frame form keep their values.
- R10: A complete command with any opcode other than 4'h1 or 4'h2 changes neither the channel nor the frame form.
- R11: Serial-clock and data activity while chip select is high produces no request and alters no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial command data from the host |
| sdo_o | output | 1 | Serial result data |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| samp_req_o | output | 1 | One-cycle request for a new sample |
| samp_ch_o | output | 2 | Channel to be sampled for this frame |
| samp_vld_i | input | 1 | Result strobe from the converter core |
| samp_data_i | input | 16 | Conversion result |

## Verification
The bench aims at the one-frame lag of the channel. A design that applied a select command in the same frame would request the wrong channel on every frame that changes it. Aborted frames with a select opcode and complete frames with unused opcodes are mixed in. Decoding a partial word, or treating every opcode as a select, would then corrupt the channel that a later request carries. The short form is switched on and off again while frames run past their own length. An off-by-one in the 15-edge preamble, a late switch of frame form, or a data bit leaking into the trailing low phase would each show up as a wrong bit at a specific edge. Serial-clock toggles during idle catch a design that counts edges or raises requests without chip select.

// File: rtl/sar_if_pkg.sv
package sar_if_pkg;

   localparam int CMD_W = 16;
   localparam int OP_W  = 4;
   localparam int ARG_W = 2;

   localparam logic [OP_W-1:0] OP_SEL_CH    = 4'h1;
   localparam logic [OP_W-1:0] OP_FRAME_LEN = 4'h2;

   typedef enum logic {
      LEN_LONG  = 1'b0,
      LEN_SHORT = 1'b1
   } flen_e;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sar_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= {STAGES{RST_VAL[b]}};
         else        pipe <= {pipe[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = pipe[STAGES-1];
   end

endmodule

// File: rtl/sar_cmd_rx.sv
module sar_cmd_rx
   import sar_if_pkg::*;
#(
   parameter int CH_W  = 2,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             active,
   input  logic             sclk_fall,
   input  logic             sdi,
   output logic [CNT_W-1:0] edge_cnt,
   output logic [CH_W-1:0]  cfg_ch,
   output flen_e            cfg_len
);

   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam int               ARG_LO   = CMD_W - ARG_W;

   logic [OP_W-1:0]  op_q;
   logic [ARG_W-1:0] arg_q;
   logic [ARG_W-1:0] arg_next;
   logic             shift_en;
   logic             word_done;

   assign shift_en  = active && sclk_fall;
   assign arg_next  = {arg_q[ARG_W-2:0], sdi};
   assign word_done = shift_en && (int'(edge_cnt) == CMD_W - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
         op_q     <= '0;
         arg_q    <= '0;
      end else if (frame_start) begin
         edge_cnt <= '0;
         op_q     <= '0;
         arg_q    <= '0;
      end else if (shift_en) begin
         if (edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
         if (int'(edge_cnt) < OP_W) op_q <= {op_q[OP_W-2:0], sdi};
         if (int'(edge_cnt) >= ARG_LO && int'(edge_cnt) < CMD_W) arg_q <= arg_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_ch  <= '0;
         cfg_len <= LEN_LONG;
      end else if (word_done && !frame_start) begin
         case (op_q)
            OP_SEL_CH:    cfg_ch  <= arg_next[CH_W-1:0];
            OP_FRAME_LEN: cfg_len <= flen_e'(arg_next[0]);
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sar_sdo_tx.sv
module sar_sdo_tx
   import sar_if_pkg::*;
#(
   parameter int RES_W   = 16,
   parameter int SHORT_W = 8,
   parameter int CNT_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             active,
   input  logic             sclk_fall,
   input  logic [CNT_W-1:0] edge_cnt,
   input  flen_e            frame_len,
   input  logic [RES_W-1:0] result,
   output logic             sdo_q
);

   logic [CNT_W:0] next_n;
   int             nbits;
   logic           nxt_bit;

   assign next_n = {1'b0, edge_cnt} + 1'b1;

   if (SHORT_W == RES_W) begin : g_single_len
      assign nbits = RES_W;
   end else begin : g_two_len
      assign nbits = (frame_len == LEN_SHORT) ? SHORT_W : RES_W;
   end

   always_comb begin
      nxt_bit = 1'b0;
      for (int k = 0; k < RES_W; k++) begin
         if ((int'(next_n) == CMD_W + k) && (k < nbits)) nxt_bit = result[RES_W-1-k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    sdo_q <= 1'b0;
      else if (clear)                sdo_q <= 1'b0;
      else if (active && sclk_fall)  sdo_q <= nxt_bit;
   end

endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
   import sar_if_pkg::*;
#(
   parameter int N_CH        = 4,
   parameter int RES_W       = 16,
   parameter int SHORT_W     = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_i,
   input  logic             sclk_i,
   input  logic             sdi_i,
   output logic             sdo_o,
   output logic             sdo_oe_o,
   output logic             samp_req_o,
   output logic [CH_W-1:0]  samp_ch_o,
   input  logic             samp_vld_i,
   input  logic [RES_W-1:0] samp_data_i
);

   localparam int CNT_W = $clog2(CMD_W + RES_W + 2);

   if (N_CH < 2 || CH_W > ARG_W) begin : g_bad_nch
      $error("sar_serial_port: N_CH must lie between 2 and 4");
   end
   if (SHORT_W < 1 || SHORT_W > RES_W) begin : g_bad_short
      $error("sar_serial_port: SHORT_W must lie between 1 and RES_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sar_serial_port: SYNC_STAGES must be at least 2");
   end

   logic [2:0]       pins_s;
   logic             cs_s, sclk_s, sdi_s;
   logic             cs_prev, sclk_prev;
   logic             cs_fall, cs_rise, sclk_fall, active;
   logic [CNT_W-1:0] edge_cnt;
   logic [CH_W-1:0]  cfg_ch;
   flen_e            cfg_len;
   flen_e            frame_len;
   logic [CH_W-1:0]  frame_ch;
   logic [RES_W-1:0] result_q;
   logic             sdo_q;
   logic             req_q;

   sar_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_n_i, sclk_i, sdi_i}),
      .q_o   (pins_s)
   );

   assign {cs_s, sclk_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev   <= 1'b1;
         sclk_prev <= 1'b1;
      end else begin
         cs_prev   <= cs_s;
         sclk_prev <= sclk_s;
      end
   end

   assign cs_fall   = cs_prev & ~cs_s;
   assign cs_rise   = ~cs_prev & cs_s;
   assign sclk_fall = sclk_prev & ~sclk_s;
   assign active    = ~cs_s;

   sar_cmd_rx #(
      .CH_W  (CH_W),
      .CNT_W (CNT_W)
   ) u_cmd_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (cs_fall),
      .active      (active),
      .sclk_fall   (sclk_fall),
      .sdi         (sdi_s),
      .edge_cnt    (edge_cnt),
      .cfg_ch      (cfg_ch),
      .cfg_len     (cfg_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_ch  <= '0;
         frame_len <= LEN_LONG;
         req_q     <= 1'b0;
      end else begin
         req_q <= cs_fall;
         if (cs_fall) begin
            frame_ch  <= cfg_ch;
            frame_len <= cfg_len;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          result_q <= '0;
      else if (samp_vld_i) result_q <= samp_data_i;
   end

   sar_sdo_tx #(
      .RES_W   (RES_W),
      .SHORT_W (SHORT_W),
      .CNT_W   (CNT_W)
   ) u_sdo_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (cs_fall | cs_rise),
      .active    (active),
      .sclk_fall (sclk_fall),
      .edge_cnt  (edge_cnt),
      .frame_len (frame_len),
      .result    (result_q),
      .sdo_q     (sdo_q)
   );

   assign sdo_oe_o   = active;
   assign sdo_o      = active & sdo_q;
   assign samp_req_o = req_q;
   assign samp_ch_o  = frame_ch;

endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk
   import sar_if_pkg::*;
#(
   parameter int CH_W    = 2,
   parameter int CNT_W   = 6,
   parameter int RES_W   = 16,
   parameter int SHORT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sdo_o,
   input logic             sdo_oe_o,
   input logic             samp_req_o,
   input logic [CH_W-1:0]  samp_ch_o,
   input logic [CNT_W-1:0] edge_cnt,
   input flen_e            frame_len
);

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      samp_req_o |=> !samp_req_o); // R2

   AST_REQ_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      samp_req_o |-> sdo_oe_o); // R2

   AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe_o |-> !sdo_o); // R1

   AST_PREAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe_o && int'(edge_cnt) < CMD_W) |-> !sdo_o); // R5

   AST_LONG_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe_o && frame_len == LEN_LONG && int'(edge_cnt) >= CMD_W + RES_W) |-> !sdo_o); // R7

   AST_SHORT_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe_o && frame_len == LEN_SHORT && int'(edge_cnt) >= CMD_W + SHORT_W) |-> !sdo_o); // R8

   AST_CH_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe_o && !samp_req_o) |-> $stable(samp_ch_o)); // R3

endmodule

bind sar_serial_port sar_serial_port_chk #(
   .CH_W    (CH_W),
   .CNT_W   (CNT_W),
   .RES_W   (RES_W),
   .SHORT_W (SHORT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sdo_o      (sdo_o),
   .sdo_oe_o   (sdo_oe_o),
   .samp_req_o (samp_req_o),
   .samp_ch_o  (samp_ch_o),
   .edge_cnt   (edge_cnt),
   .frame_len  (frame_len)
);

// File: tb/sar_serial_port_tb.sv
module sar_serial_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic        sdi = 1'b0;
   logic        vld = 1'b0;
   logic [15:0] data = '0;
   logic        sdo_o, sdo_oe_o, samp_req_o;
   logic [1:0]  samp_ch_o;

   always #4 clk = ~clk;

   sar_serial_port u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_i      (cs_n),
      .sclk_i      (sclk),
      .sdi_i       (sdi),
      .sdo_o       (sdo_o),
      .sdo_oe_o    (sdo_oe_o),
      .samp_req_o  (samp_req_o),
      .samp_ch_o   (samp_ch_o),
      .samp_vld_i  (vld),
      .samp_data_i (data)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 0;
   bit    exp_q[$];
   string tag_q[$];
   int    edge_q[$];
   logic [1:0] ch_q[$];
   string ctag_q[$];
   event  smp_ev;

   logic [1:0] m_ch = 2'd0;
   bit         m_short = 1'b0;
   int         fid = 0;
   int         req_seen = 0;

   function automatic logic [15:0] conv(input int ch, input int f);
      return (16'hA5C3 + 16'(f) * 16'h1357) ^ (16'(ch) * 16'h0F0F);
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // converter model and request monitor
   int         cdly = 0;
   int         cfid = 0;
   logic [1:0] cch  = '0;
   always @(negedge clk) begin
      vld = 1'b0;
      if (samp_req_o) begin
         cfid++;
         req_seen++;
         cch  = samp_ch_o;
         cdly = 3;
         if (ch_q.size() > 0) begin
            logic [1:0] e;
            string      t;
            e = ch_q.pop_front();
            t = ctag_q.pop_front();
            chk(samp_ch_o == e, t, "requested channel", samp_ch_o, e);
         end else begin
            chk(1'b0, "R2", "unexpected sample request", 1, 0);
         end
      end else if (cdly > 0) begin
         cdly--;
         if (cdly == 0) begin
            vld  = 1'b1;
            data = conv(cch, cfid);
         end
      end
   end

   // scoreboard monitor for serial output bits
   always @(smp_ev) begin
      bit    b;
      string t;
      int    e;
      b = exp_q.pop_front();
      t = tag_q.pop_front();
      e = edge_q.pop_front();
      chk(sdo_oe_o && (sdo_o === b), t, $sformatf("sdo after edge %0d", e),
          {sdo_oe_o, sdo_o}, {1'b1, b});
   end

   task automatic run_frame(input logic [15:0] cmd, input int ne, input string ctag);
      logic [15:0] r;
      int          nbits;
      fid++;
      ch_q.push_back(m_ch);
      ctag_q.push_back(ctag);
      r     = conv(m_ch, fid);
      nbits = m_short ? 8 : 16;
      for (int e = 1; e <= ne; e++) begin
         bit    b;
         string t;
         b = (e >= 16 && e < 16 + nbits) ? r[15 - (e - 16)] : 1'b0;
         if (e < 16)               t = "R5";
         else if (m_short)         t = "R8";
         else if (e < 16 + nbits)  t = "R6";
         else                      t = "R7";
         exp_q.push_back(b);
         tag_q.push_back(t);
         edge_q.push_back(e);
      end
      @(negedge clk) cs_n = 1'b0;
      repeat (6) @(negedge clk);
      chk(sdo_oe_o && !sdo_o, "R1", "line driven low at frame start", {sdo_oe_o, sdo_o}, 2'b10);
      for (int e = 1; e <= ne; e++) begin
         sdi = (e <= 16) ? cmd[16 - e] : 1'b0;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
         repeat (8) @(negedge clk);
         -> smp_ev;
         sclk = 1'b1;
         repeat (4) @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(!sdo_oe_o && !sdo_o, "R1", "line floated after frame", {sdo_oe_o, sdo_o}, 0);
      chk(req_seen == fid, "R2", "requests per frame", req_seen, fid);
      if (ne >= 16) begin
         case (cmd[15:12])
            4'h1:    m_ch = cmd[1:0];
            4'h2:    m_short = cmd[0];
            default: ;
         endcase
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk(!sdo_oe_o && !samp_req_o && samp_ch_o == 2'd0, "R1", "reset state",
          {sdo_oe_o, samp_req_o, samp_ch_o}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      run_frame(16'h1002, 32, "R3");  // selects ch2, this frame still ch0
      run_frame(16'h1001, 32, "R4");  // ch2 now, selects ch1
      run_frame(16'h2001, 32, "R3");  // ch1, long form still in force
      run_frame(16'h0000, 28, "R8");  // short form active, frame runs past 24
      run_frame(16'h1003, 10, "R3");  // aborted select
      run_frame(16'h7003, 20, "R9");  // ch1 survives abort; opcode 7 no-op
      run_frame(16'h2000, 32, "R10"); // ch1 survives no-op, back to long

      // R11: idle activity while chip select is high
      for (int i = 0; i < 20; i++) begin
         sdi  = i[0];
         sclk = ~sclk;
         repeat (6) @(negedge clk);
         chk(!sdo_oe_o && !sdo_o, "R11", "idle line stays floated", {sdo_oe_o, sdo_o}, 0);
      end
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      chk(req_seen == fid, "R11", "no request while idle", req_seen, fid);

      run_frame(16'h1003, 34, "R11"); // ch1 unchanged by idle toggles, long tail
      run_frame(16'h0000, 32, "R4");  // ch3 selected previously

      repeat (10) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (60000) @(posedge clk);
      chk(1'b0, "R2", "watchdog expired", 0, 1);
      finish_run();
   end

endmodule